// File: doc/BRIEF.md
# Signal-Strength Capture and Receiver Gain Control

This block holds the last signal-strength measurement of a receiver and the three bits that set the receiver gain. The receive datapath supplies a live 5-bit strength value and a strobe marking the start of each incoming packet. The block decides in which cycle that live value is copied into a result register. It then shows the stored value and a fresh-data flag on a register read port.

Two events request a new measurement. One is a start-of-packet strobe. The other is any read of the result register, so that repeated reads with no traffic follow the background energy on the channel. Successive measurements are kept at least `MIN_GAP_CYC` clock cycles apart. With the default of 600 cycles at 50 MHz this gives 12 µs. A request that arrives inside that window is held and is served in the first cycle the window allows. The gain bits are loaded by a plain write strobe. A derived output gives how many 20 dB attenuation steps are currently in force.

Top module: `rssi_gain_ctrl`

## Requirements
- R1: After reset, `res_data` is 0, `res_valid` is 0, `agc_en`=1, `lna_en`=1, `att_en`=0 and `atten_steps`=0, and a measurement may be taken at once.
- R2: With `meas_en`=1 and the spacing window expired, a cycle with `sop_det`=1 copies that cycle's `strength_in` into the result. The copy shows on `res_data` with `res_valid`=1 in the next cycle.
- R3: A cycle with `res_rd`=1 and `meas_en`=1 requests a measurement. The earliest measurement it can cause samples `strength_in` in the cycle after the read.
- R4: Two measurements are at least `MIN_GAP_CYC` cycles apart. A request (a read, or a start-of-packet strobe) that falls inside the window is held and is served in the first cycle the window allows. Further requests do not restart the window.
- R5: `res_valid` is set by every measurement. A read cleared it unless a measurement lands in the same cycle. `res_data` always shows the stored value, including when `res_valid`=0.
- R6: A start-of-packet strobe and a held request that become due in the same cycle produce one measurement, which consumes the held request.
- R7: While `meas_en`=0, no measurement is taken, held requests are discarded and the stored value does not change.
- R8: A cycle with `gain_wr`=1 loads `gain_wdata`: bit 2 sets `agc_en`, bit 1 sets `lna_en` and bit 0 sets `att_en`. Without `gain_wr`, the three bits hold their values.
- R9: `atten_steps` equals the sum of two terms. The first term is 1 when `agc_en`=0 and `lna_en`=0, and 0 otherwise. The second term is 1 when `att_en`=1. Each step is about 20 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_en | input | 1 | Automatic measurement enable |
| sop_det | input | 1 | Start-of-packet strobe from the packet detector |
| strength_in | input | SW | Live signal-strength value from the receive path |
| res_rd | input | 1 | Read strobe for the result register |
| res_data | output | SW | Stored strength result |
| res_valid | output | 1 | A measurement has landed since the last read |
| gain_wr | input | 1 | Write strobe for the gain bits |
| gain_wdata | input | 3 | Gain bits to load: {agc, lna, att} |
| agc_en | output | 1 | Automatic gain control enabled |
| lna_en | output | 1 | Low-noise amplifier at full gain |
| att_en | output | 1 | Extra attenuator engaged |
| atten_steps | output | 2 | Number of 20 dB attenuation steps in force |

## Verification
The bench changes `strength_in` in every cycle, so each value tells which cycle it was sampled in. A read placed at every offset inside and just past the spacing window exposes three faults. A design that samples early breaks the minimum spacing, one that samples late returns a value one or more cycles off, and one that restarts the window on each request waits too long. A start-of-packet strobe that lands together with a due held request must give exactly one measurement. A design that keeps the request would take a second measurement one window later. With the enable cleared, strobes and reads must leave the stored value alone. A design that keeps held requests would measure once the enable returns. All eight gain codes are written, and the attenuation-step count is compared with the arithmetic sum.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
  typedef struct packed {
    logic agc;
    logic lna;
    logic att;
  } gain_cfg_t;

  localparam int GAIN_W = 3;
endpackage

// File: rtl/rssi_gap_timer.sv
module rssi_gap_timer #(
  parameter int MIN_GAP_CYC = 600,
  parameter int CW          = $clog2(MIN_GAP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= CW'(MIN_GAP_CYC - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // the sampler only loads the window once the previous window is over
  assert_load_when_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> expired);
endmodule

// File: rtl/rssi_sampler.sv
module rssi_sampler #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sop,
  input  logic          rd,
  input  logic          gap_open,
  input  logic [SW-1:0] strength,
  output logic          take,
  output logic [SW-1:0] result,
  output logic          valid
);
  logic pend_q;
  logic req;

  assign req  = sop | pend_q;
  assign take = en & gap_open & req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      result <= '0;
      valid  <= 1'b0;
    end else begin
      if (!en)       pend_q <= 1'b0;
      else if (take) pend_q <= rd;
      else           pend_q <= pend_q | sop | rd;

      if (take) result <= strength;

      if (take)    valid <= 1'b1;
      else if (rd) valid <= 1'b0;
    end
  end

  assert_valid_on_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> valid);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !take) |=> !valid);
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(result));
endmodule

// File: rtl/rssi_gain_regs.sv
module rssi_gain_regs
  import rssi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [GAIN_W-1:0] wdata,
  output gain_cfg_t         cfg,
  output logic [1:0]        steps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= '{agc: 1'b1, lna: 1'b1, att: 1'b0};
    else if (wr) cfg <= gain_cfg_t'(wdata);
  end

  assign steps = {1'b0, (!cfg.agc && !cfg.lna)} + {1'b0, cfg.att};

  assert_gain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg));
  assert_steps_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    steps <= 2'd2);
endmodule

// File: rtl/rssi_gain_ctrl.sv
module rssi_gain_ctrl
  import rssi_pkg::*;
#(
  parameter int SW          = 5,
  parameter int MIN_GAP_CYC = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_en,
  input  logic              sop_det,
  input  logic [SW-1:0]     strength_in,
  input  logic              res_rd,
  output logic [SW-1:0]     res_data,
  output logic              res_valid,
  input  logic              gain_wr,
  input  logic [GAIN_W-1:0] gain_wdata,
  output logic              agc_en,
  output logic              lna_en,
  output logic              att_en,
  output logic [1:0]        atten_steps
);
  localparam int CW = $clog2(MIN_GAP_CYC + 1);

  logic      take;
  logic      gap_open;
  gain_cfg_t cfg;

  rssi_gap_timer #(.MIN_GAP_CYC(MIN_GAP_CYC), .CW(CW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(take), .expired(gap_open)
  );

  rssi_sampler #(.SW(SW)) u_samp (
    .clk(clk), .rst_n(rst_n), .en(meas_en), .sop(sop_det), .rd(res_rd),
    .gap_open(gap_open), .strength(strength_in), .take(take),
    .result(res_data), .valid(res_valid)
  );

  rssi_gain_regs u_gain (
    .clk(clk), .rst_n(rst_n), .wr(gain_wr), .wdata(gain_wdata),
    .cfg(cfg), .steps(atten_steps)
  );

  assign agc_en = cfg.agc;
  assign lna_en = cfg.lna;
  assign att_en = cfg.att;

  // independent spacing monitor: cycles since the last measurement
  logic [CW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_q <= CW'(MIN_GAP_CYC);
    else if (take)                        since_q <= CW'(1);
    else if (since_q < CW'(MIN_GAP_CYC))  since_q <= since_q + 1'b1;
  end

  assert_min_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (since_q >= CW'(MIN_GAP_CYC)));
endmodule

// File: tb/rssi_gain_ctrl_tb.sv
module rssi_gain_ctrl_tb;
  localparam int SW  = 5;
  localparam int GAP = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic meas_en = 0, sop_det = 0, res_rd = 0, gain_wr = 0;
  logic [SW-1:0] strength_in = '0;
  logic [2:0] gain_wdata = '0;
  logic [SW-1:0] res_data;
  logic res_valid, agc_en, lna_en, att_en;
  logic [1:0] atten_steps;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  rssi_gain_ctrl #(.SW(SW), .MIN_GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .sop_det(sop_det),
    .strength_in(strength_in), .res_rd(res_rd), .res_data(res_data),
    .res_valid(res_valid), .gain_wr(gain_wr), .gain_wdata(gain_wdata),
    .agc_en(agc_en), .lna_en(lna_en), .att_en(att_en), .atten_steps(atten_steps)
  );

  function automatic int fval(input int c);
    return (c * 7 + 3) % 32;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
    strength_in = SW'(fval(cyc));
  endtask

  // clears valid and any held request, and lets the window run out
  task automatic quiesce();
    meas_en = 0; sop_det = 0; res_rd = 1;
    step();
    res_rd = 0;
    for (int i = 0; i < GAP + 2; i++) step();
    meas_en = 1;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int c0, tk, snap;
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    chk(res_data == 0, "R1 data", res_data, 0);
    chk(res_valid == 0, "R1 valid", res_valid, 0);
    chk({agc_en, lna_en, att_en} == 3'b110, "R1 gain", {agc_en, lna_en, att_en}, 6);
    chk(atten_steps == 0, "R1 steps", atten_steps, 0);

    // R1/R2: first sop right after reset is taken at once
    meas_en = 1; sop_det = 1; c0 = cyc;
    step(); sop_det = 0;
    chk(res_data == SW'(fval(c0)), "R1 R2 first take", res_data, fval(c0));
    chk(res_valid == 1, "R2 valid", res_valid, 1);

    // R3/R4/R5: read at every offset d after a sop
    for (int d = 1; d <= 10; d++) begin
      quiesce();
      c0 = cyc;
      tk = (d + 1 > GAP) ? d + 1 : GAP;
      for (int k = 0; k <= 13; k++) begin
        sop_det = (k == 0);
        res_rd  = (k == d);
        if (k == d) begin
          chk(res_data == SW'(fval(c0)), "R5 read data", res_data, fval(c0));
          chk(res_valid == 1, "R5 valid before read", res_valid, 1);
        end
        if (k == tk) chk(res_valid == 0, "R5 valid cleared", res_valid, 0);
        if (k == 13) begin
          chk(res_data == SW'(fval(c0 + tk)), "R3 R4 read-triggered sample", res_data, fval(c0 + tk));
          chk(res_valid == 1, "R5 valid after take", res_valid, 1);
        end
        step();
      end
      sop_det = 0; res_rd = 0;
    end

    // R4: repeated requests inside the window do not restart it
    quiesce();
    c0 = cyc;
    for (int k = 0; k <= 10; k++) begin
      sop_det = (k == 0 || k == 5);
      res_rd  = (k == 2);
      if (k == GAP) chk(res_data == SW'(fval(c0)), "R4 no early take", res_data, fval(c0));
      if (k == 10) chk(res_data == SW'(fval(c0 + GAP)), "R4 held requests served", res_data, fval(c0 + GAP));
      step();
    end
    sop_det = 0; res_rd = 0;

    // R6: sop and held request due together -> one measurement
    quiesce();
    c0 = cyc;
    for (int k = 0; k <= 2 * GAP + 2; k++) begin
      sop_det = (k == 0 || k == GAP);
      res_rd  = (k == 2);
      if (k == GAP + 1) chk(res_data == SW'(fval(c0 + GAP)), "R6 merged take", res_data, fval(c0 + GAP));
      if (k == 2 * GAP + 2) chk(res_data == SW'(fval(c0 + GAP)), "R6 no second take", res_data, fval(c0 + GAP));
      step();
    end
    sop_det = 0; res_rd = 0;

    // R7: disabled -> no measurement, held requests dropped
    quiesce();
    sop_det = 1; step(); sop_det = 0;
    snap = int'(res_data);
    for (int i = 0; i < GAP + 2; i++) step();
    meas_en = 0;
    for (int k = 0; k < 6; k++) begin
      sop_det = k[0];
      res_rd  = (k == 2);
      step();
    end
    sop_det = 0; res_rd = 0;
    chk(int'(res_data) == snap, "R7 unchanged while off", res_data, snap);
    chk(res_valid == 0, "R5 read while off clears", res_valid, 0);
    res_rd = 1; step(); res_rd = 0; meas_en = 0; step();
    meas_en = 1;
    for (int i = 0; i < GAP + 3; i++) step();
    chk(int'(res_data) == snap, "R7 request dropped", res_data, snap);

    // R8/R9: all gain codes
    for (int v = 0; v < 8; v++) begin
      int exp_steps;
      gain_wdata = 3'(v); gain_wr = 1;
      step();
      gain_wr = 0; gain_wdata = 3'(~v);
      step();
      exp_steps = ((v & 4) == 0 && (v & 2) == 0 ? 1 : 0) + (v & 1);
      chk({agc_en, lna_en, att_en} == 3'(v), "R8 gain bits held", {agc_en, lna_en, att_en}, v);
      chk(int'(atten_steps) == exp_steps, "R9 steps", atten_steps, exp_steps);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule